// File: doc/BRIEF.md
# Stream-to-Memory Frame Writer

This block accepts a valid/ready data stream (typically pixels of one video frame after another) and writes each beat to memory through a word-wide memory-mapped write master that obeys a waitrequest stall input. Where the data lands is set by transfer descriptors. A descriptor carries a destination byte address and a byte count, and it is committed with a single 128-bit write. Descriptors queue in a small FIFO and run strictly in order. Incoming beats queue in a separate data FIFO.

The stream side never sees the memory directly. Its ready follows only the data FIFO's free space, so the block absorbs short memory stalls. A descriptor waiting for data simply idles, with no timeout. When one descriptor finishes, the next queued one takes the following beat at once. The block runs on a single clock. Any clock crossing belongs upstream.

Top module: `stream_mem_writer`

## Requirements
- R1: `s_ready_o` is high exactly when the data FIFO holds fewer than `DATA_DEPTH` beats. A beat offered with `s_valid_i` and `s_ready_o` both high is accepted and stored, whether or not a descriptor is active.
- R2: Every accepted beat is written to memory exactly once, unchanged, in arrival order.
- R3: The first write of a descriptor goes to the descriptor's address. Each later write goes to the previous address plus `DATA_W/8`. A descriptor issues exactly length/(`DATA_W/8`) writes.
- R4: While `m_write_o` is high and `m_waitreq_i` is high, the following cycle keeps `m_write_o` high with the same `m_addr_o` and `m_wdata_o`.
- R5: While the memory stalls, beats keep being accepted until `DATA_DEPTH` are buffered. Only then does `s_ready_o` go low.
- R6: The descriptor word uses bits [31:0] for the byte address, bits [63:32] for the byte length, and bit 64 as go. A write on `desc_wr_i` is queued only if all of the following hold: go is 1, bits [127:65] are zero, the address and the length are multiples of `DATA_W/8`, the length is nonzero and at most `MAX_BYTES`, and the descriptor FIFO is not full. Any other write is ignored.
- R7: Descriptors execute in the order they were queued. After the final write of one is accepted, a queued successor issues its first write on the very next cycle if data is buffered.
- R8: With no descriptor active, or with no buffered data, `m_write_o` stays low. A descriptor waiting for data waits indefinitely.
- R9: `desc_empty_o` and `desc_full_o` report a descriptor FIFO with zero entries and with `DESC_DEPTH` entries. `busy_o` is high while a descriptor is being executed. A queued descriptor is taken up one cycle after it is queued.
- R10: `done_o` is high for the one cycle that follows acceptance of each descriptor's final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_wr_i | input | 1 | Descriptor write strobe |
| desc_word_i | input | 128 | Descriptor word |
| desc_full_o | output | 1 | Descriptor FIFO full |
| desc_empty_o | output | 1 | Descriptor FIFO empty |
| s_valid_i | input | 1 | Stream beat valid |
| s_data_i | input | DATA_W | Stream beat data |
| s_ready_o | output | 1 | Stream ready (data FIFO not full) |
| m_write_o | output | 1 | Memory write request |
| m_addr_o | output | 32 | Memory byte address |
| m_wdata_o | output | DATA_W | Memory write data |
| m_waitreq_i | input | 1 | Memory stall |
| busy_o | output | 1 | Descriptor in execution |
| done_o | output | 1 | Descriptor completion pulse |

## Verification
The bench targets four cases:

- **Data before any descriptor.** Beats arrive ahead of every descriptor. A design that gated ready on an active descriptor would stall the stream. One that wrote without an address would corrupt memory.
- **Full stall with a full data FIFO.** The memory stalls completely while the data FIFO fills. The bench checks that ready drops at exactly `DATA_DEPTH` beats, and that address and data hold steady under waitrequest. An off-by-one full flag, or a master that advances while stalled, shows up here.
- **Descriptor FIFO filled past its depth, then single-word runs.** The descriptor FIFO is overfilled and then drained. Single-word descriptors run back to back. A lost or duplicated descriptor, a gap cycle, or a wrong retire count would each misplace writes or drop a `done_o` pulse.
- **Malformed descriptors.** These are misaligned, zero-length, too long, not marked go, or have reserved bits set. None of them may queue.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int DESC_W       = 128;
  localparam int DESC_ADDR_LO = 0;
  localparam int DESC_LEN_LO  = 32;
  localparam int DESC_GO_BIT  = 64;
  localparam int MEM_ADDR_W   = 32;

  function automatic logic [31:0] desc_addr(input logic [DESC_W-1:0] w);
    return w[DESC_ADDR_LO +: 32];
  endfunction

  function automatic logic [31:0] desc_len(input logic [DESC_W-1:0] w);
    return w[DESC_LEN_LO +: 32];
  endfunction
endpackage

// File: rtl/swr_fifo.sv
module swr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/swr_desc_dec.sv
module swr_desc_dec
  import swr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 4096,
  parameter int LEN_W     = 11
) (
  input  logic                         wr_i,
  input  logic [DESC_W-1:0]            word_i,
  input  logic                         fifo_full_i,
  output logic                         push_o,
  output logic [MEM_ADDR_W+LEN_W-1:0]  entry_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int AL    = $clog2(BYTES);

  logic [31:0] addr, len;
  logic        aligned, len_ok, rsv_ok;

  assign addr    = desc_addr(word_i);
  assign len     = desc_len(word_i);
  assign aligned = (addr[AL-1:0] == '0) && (len[AL-1:0] == '0);
  assign len_ok  = (len != '0) && (len <= 32'(MAX_BYTES));
  assign rsv_ok  = (word_i[DESC_W-1:DESC_GO_BIT+1] == '0);
  assign push_o  = wr_i && word_i[DESC_GO_BIT] && rsv_ok && aligned && len_ok && !fifo_full_i;
  assign entry_o = {addr, len[AL +: LEN_W]};
endmodule

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        desc_empty_i,
  input  logic [MEM_ADDR_W+LEN_W-1:0] desc_i,
  output logic                        desc_pop_o,
  input  logic                        data_empty_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic                        data_pop_o,
  output logic                        m_write_o,
  output logic [MEM_ADDR_W-1:0]       m_addr_o,
  output logic [DATA_W-1:0]           m_wdata_o,
  input  logic                        m_waitreq_i,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int BYTES = DATA_W / 8;

  logic                  active_q, done_q;
  logic [MEM_ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]      left_q;
  logic                  acc, retire, load;

  assign m_write_o  = active_q && !data_empty_i;
  assign acc        = m_write_o && !m_waitreq_i;
  assign retire     = acc && (left_q == LEN_W'(1));
  assign load       = (!active_q || retire) && !desc_empty_i;
  assign desc_pop_o = load;
  assign data_pop_o = acc;
  assign m_addr_o   = addr_q;
  assign m_wdata_o  = data_i;
  assign busy_o     = active_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
    end else begin
      done_q <= retire;
      if (load) begin
        active_q <= 1'b1;
        addr_q   <= desc_i[LEN_W +: MEM_ADDR_W];
        left_q   <= desc_i[LEN_W-1:0];
      end else begin
        if (acc) begin
          addr_q <= addr_q + MEM_ADDR_W'(BYTES);
          left_q <= left_q - 1'b1;
        end
        if (retire) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stream_mem_writer.sv
module stream_mem_writer
  import swr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DATA_DEPTH = 8,
  parameter int DESC_DEPTH = 4,
  parameter int MAX_BYTES  = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_wr_i,
  input  logic [127:0]      desc_word_i,
  output logic              desc_full_o,
  output logic              desc_empty_o,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              m_write_o,
  output logic [31:0]       m_addr_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic              m_waitreq_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int BYTES   = DATA_W / 8;
  localparam int LEN_W   = $clog2(MAX_BYTES / BYTES + 1);
  localparam int ENTRY_W = MEM_ADDR_W + LEN_W;

  logic               d_push, d_pop, d_full, d_empty;
  logic [ENTRY_W-1:0] d_in, d_out;
  logic               x_pop, x_full, x_empty;
  logic [DATA_W-1:0]  x_out;

  swr_desc_dec #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_dec (
    .wr_i(desc_wr_i), .word_i(desc_word_i), .fifo_full_i(d_full),
    .push_o(d_push), .entry_o(d_in)
  );

  swr_fifo #(.W(ENTRY_W), .DEPTH(DESC_DEPTH)) u_desc_fifo (
    .clk_i, .rst_ni, .push_i(d_push), .wdata_i(d_in), .pop_i(d_pop),
    .rdata_o(d_out), .full_o(d_full), .empty_o(d_empty)
  );

  swr_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk_i, .rst_ni, .push_i(s_valid_i), .wdata_i(s_data_i), .pop_i(x_pop),
    .rdata_o(x_out), .full_o(x_full), .empty_o(x_empty)
  );

  swr_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .desc_empty_i(d_empty), .desc_i(d_out), .desc_pop_o(d_pop),
    .data_empty_i(x_empty), .data_i(x_out), .data_pop_o(x_pop),
    .m_write_o, .m_addr_o, .m_wdata_o, .m_waitreq_i,
    .busy_o, .done_o
  );

  assign s_ready_o    = !x_full;
  assign desc_full_o  = d_full;
  assign desc_empty_o = d_empty;
endmodule

// File: rtl/stream_mem_writer_chk.sv
module stream_mem_writer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic              m_write_o,
  input logic [31:0]       m_addr_o,
  input logic [DATA_W-1:0] m_wdata_o,
  input logic              m_waitreq_i,
  input logic              desc_full_o,
  input logic              desc_empty_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_write_o && m_waitreq_i |=> m_write_o && $stable(m_addr_o) && $stable(m_wdata_o)); // R4
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !m_write_o); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(m_write_o && !m_waitreq_i)); // R10
  AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(s_ready_o) |-> $past(s_valid_i)); // R5
  AST_DESC_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_full_o && desc_empty_o)); // R9
endmodule

bind stream_mem_writer stream_mem_writer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .m_write_o(m_write_o), .m_addr_o(m_addr_o), .m_wdata_o(m_wdata_o),
  .m_waitreq_i(m_waitreq_i), .desc_full_o(desc_full_o), .desc_empty_o(desc_empty_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/stream_mem_writer_bench.sv
module stream_mem_writer_bench;
  localparam int DATA_W = 32, DATA_DEPTH = 8, DESC_DEPTH = 4, MAX_BYTES = 4096;
  localparam int BYTES = DATA_W / 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic desc_wr = 1'b0;
  logic [127:0] desc_word = '0;
  logic s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic m_waitreq = 1'b0;
  logic desc_full, desc_empty, s_ready, m_write, busy, done;
  logic [31:0] m_addr;
  logic [DATA_W-1:0] m_wdata;

  always #4 clk = ~clk;

  stream_mem_writer #(.DATA_W(DATA_W), .DATA_DEPTH(DATA_DEPTH), .DESC_DEPTH(DESC_DEPTH),
                      .MAX_BYTES(MAX_BYTES)) u_stream_mem_writer (
    .clk_i(clk), .rst_ni, .desc_wr_i(desc_wr), .desc_word_i(desc_word),
    .desc_full_o(desc_full), .desc_empty_o(desc_empty), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(s_ready), .m_write_o(m_write), .m_addr_o(m_addr),
    .m_wdata_o(m_wdata), .m_waitreq_i(m_waitreq), .busy_o(busy), .done_o(done)
  );

  int checks = 0, errors = 0, done_seen = 0, writes_seen = 0;
  bit reported = 0;
  int wr_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // reference model
  logic [DATA_W-1:0] dq[$];
  int unsigned qa[$], qw[$];
  bit  m_active, m_done;
  int unsigned m_addr_e, m_left;
  bit  sn_valid, sn_wait, sn_dwr;
  logic [DATA_W-1:0] sn_data;
  logic [127:0] sn_word;

  function automatic bit desc_ok(input logic [127:0] w);
    int unsigned a, l;
    a = w[31:0];
    l = w[63:32];
    return w[64] && (w[127:65] == '0) && (a % BYTES == 0) && (l % BYTES == 0)
           && (l != 0) && (l <= MAX_BYTES);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dq.delete(); qa.delete(); qw.delete();
      m_active = 0; m_done = 0; m_addr_e = 0; m_left = 0;
    end else begin
      int dsz, qsz;
      bit acc, ret;
      dsz = dq.size();
      qsz = qa.size();
      acc = m_active && dsz > 0 && !sn_wait;
      ret = acc && m_left == 1;
      if (acc) begin
        void'(dq.pop_front());
        m_addr_e += BYTES;
        m_left--;
      end
      m_done = ret;
      if (ret) m_active = 0;
      if (!m_active && qsz > 0) begin
        m_addr_e = qa.pop_front();
        m_left = qw.pop_front();
        m_active = 1;
      end
      if (sn_dwr && desc_ok(sn_word) && qsz < DESC_DEPTH) begin
        qa.push_back(sn_word[31:0]);
        qw.push_back(sn_word[63:32] / BYTES);
      end
      if (sn_valid && dsz < DATA_DEPTH) dq.push_back(sn_data);
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      bit ew;
      ew = m_active && dq.size() > 0;
      chk(m_write == ew, "R8", "m_write", m_write, ew);
      if (ew && m_write) begin
        chk(m_addr == m_addr_e, "R3", "m_addr", m_addr, m_addr_e);
        chk(m_wdata == dq[0], "R2", "m_wdata", m_wdata, dq[0]);
      end
      chk(s_ready == (dq.size() < DATA_DEPTH), "R1", "s_ready", s_ready, dq.size() < DATA_DEPTH);
      chk(desc_empty == (qa.size() == 0), "R9", "desc_empty", desc_empty, qa.size() == 0);
      chk(desc_full == (qa.size() == DESC_DEPTH), "R9", "desc_full", desc_full, qa.size() == DESC_DEPTH);
      chk(busy == m_active, "R7", "busy", busy, m_active);
      chk(done == m_done, "R10", "done", done, m_done);
      if (done) done_seen++;
      if (m_write && !m_waitreq) writes_seen++;
    end
    sn_valid = s_valid; sn_data = s_data; sn_wait = m_waitreq;
    sn_dwr = desc_wr; sn_word = desc_word;
  end

  task automatic step();
    @(posedge clk);
    #2;
    case (wr_mode)
      0: m_waitreq = 1'b0;
      1: m_waitreq = 1'b1;
      default: m_waitreq = ($urandom % 3) == 0;
    endcase
  endtask

  function automatic logic [127:0] mk(input int unsigned a, input int unsigned l, input bit go);
    logic [127:0] w;
    w = '0;
    w[31:0] = a;
    w[63:32] = l;
    w[64] = go;
    return w;
  endfunction

  task automatic push_desc(input logic [127:0] w);
    desc_wr = 1'b1;
    desc_word = w;
    step();
    desc_wr = 1'b0;
  endtask

  int beat_id = 0;
  task automatic stream(input int n);
    for (int i = 0; i < n; i++) begin
      bit r;
      s_valid = 1'b1;
      s_data = DATA_W'(32'hA500_0000 + beat_id);
      r = 0;
      while (!r) begin
        r = s_ready;
        step();
      end
      beat_id++;
    end
    s_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (busy || !desc_empty); i++) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // reset state
    chk(s_ready == 1, "R1", "reset s_ready", s_ready, 1);
    chk(m_write == 0, "R8", "reset m_write", m_write, 0);
    chk(desc_empty == 1 && desc_full == 0, "R9", "reset desc flags", {desc_full, desc_empty}, 1);
    chk(busy == 0 && done == 0, "R10", "reset busy/done", {busy, done}, 0);
    rst_ni = 1'b1;
    step();

    // data ahead of any descriptor: held, not written (R1, R8)
    stream(3);
    repeat (6) step();
    chk(writes_seen == 0, "R8", "writes without descriptor", writes_seen, 0);
    push_desc(mk(32'h1000, 16, 1));
    stream(1);
    drain();
    chk(writes_seen == 4, "R3", "words for 16-byte descriptor", writes_seen, 4);

    // full memory stall: exactly DATA_DEPTH accepted (R5)
    wr_mode = 1;
    push_desc(mk(32'h2000, 16 * BYTES, 1));
    begin
      int acc_n;
      acc_n = 0;
      s_valid = 1'b1;
      for (int i = 0; i < DATA_DEPTH + 3; i++) begin
        s_data = DATA_W'(32'hA500_0000 + beat_id);
        if (s_ready) begin acc_n++; beat_id++; end
        step();
      end
      s_valid = 1'b0;
      chk(acc_n == DATA_DEPTH, "R5", "beats accepted under stall", acc_n, DATA_DEPTH);
      chk(s_ready == 0, "R5", "ready low when full", s_ready, 0);
    end
    wr_mode = 2;
    stream(16 - DATA_DEPTH);
    drain();
    chk(writes_seen == 20, "R2", "total writes after stall run", writes_seen, 20);

    // malformed descriptors ignored (R6)
    wr_mode = 0;
    push_desc(mk(32'h3000, 16, 0));
    push_desc(mk(32'h3000, 0, 1));
    push_desc(mk(32'h3000, MAX_BYTES + BYTES, 1));
    push_desc(mk(32'h3002, 16, 1));
    push_desc(mk(32'h3000, 18, 1));
    begin
      logic [127:0] w;
      w = mk(32'h3000, 16, 1);
      w[100] = 1'b1;
      push_desc(w);
    end
    repeat (3) step();
    chk(desc_empty == 1 && busy == 0, "R6", "malformed descriptors queued", {desc_empty, busy}, 2);

    // fill descriptor FIFO past depth, wait idle, then feed (R9, R8, R7)
    for (int i = 0; i < DESC_DEPTH + 2; i++) push_desc(mk(32'h4000 + i * 32'h100, 4 * BYTES, 1));
    chk(desc_full == 1, "R9", "desc_full after overfill", desc_full, 1);
    repeat (40) step();
    chk(writes_seen == 20, "R8", "no writes while data absent", writes_seen, 20);
    wr_mode = 2;
    stream((DESC_DEPTH + 1) * 4);
    drain();
    chk(writes_seen == 40, "R7", "writes for queued descriptors", writes_seen, 40);

    // single-word descriptors back to back (R7, R10)
    wr_mode = 0;
    for (int i = 0; i < 3; i++) push_desc(mk(32'h5000 + i * 32'h40, BYTES, 1));
    stream(3);
    drain();
    chk(done_seen == 10, "R10", "done pulse count", done_seen, 10);
    chk(writes_seen == 43, "R2", "final write count", writes_seen, 43);

    report();
    $finish;
  end
endmodule